// File: doc/BRIEF.md
# Pulse Driver Configuration Register File with Serial Access

This block holds the settings of a multi-level transmit pulse driver. It holds one control word and fifteen amplitude level words. The control word is an 8-bit aperture-weighting DAC code plus a bit that swaps the output polarity. Each level word is 7 bits wide. A host reaches the block through a four-wire serial port: a serial clock, a data input, a data output and an active-low select. Every transfer is a 16-bit word. Its two top bits are a command, the next four are a register address and the low ten are data.

Writes go through two stages. A complete write frame lands in a shadow copy when the select line returns high. A separate load strobe then copies every shadow value at once into the active copy, and the active copy drives the output stage. A host can therefore prepare a whole new scan-line setting while the current one is in use, and switch to it on one edge. A read-back command makes the next frame return the addressed shadow value. A power-down command forces the driven amplitudes to zero until the next valid write. An enable input freezes the whole register state.

All serial pins and the load strobe are sampled by the system clock through a synchronizer of parameterised depth. Their edges are then detected in the clock domain.

Top module: `pam_cfg_spi_regs`

## Requirements
- R1: After reset, the DAC code, the polarity bit, all fifteen levels and the power-down flag read zero, and SDO is low.
- R2: A frame is 16 bits, sampled on SCK rising edges, most significant bit first. Bits [15:14] are the command, bits [13:10] the address and bits [9:0] the data. Command 00 writes. A write to address 0 stores data bit 8 as the polarity bit and data bits 7:0 as the DAC code. Data bit 9 is ignored.
- R3: A write to address k (1..15) stores data bits 6:0 as level k, and data bits 9:7 are ignored. Level k appears on `level_o[7k-1:7k-7]`.
- R4: A write takes effect in the shadow copy when CS rises. The output ports do not change until the next LD rising edge.
- R5: An LD rising edge copies every shadow value into the active copy in the same clock cycle.
- R6: A frame whose bit count at the CS rising edge is not exactly 16 changes no register and no flag.
- R7: After a command 01 frame, the next frame shifts out on SDO, MSB first, the word {01, address, value}. The value is the shadow content, zero-extended to 10 bits; for address 0 it is {0, polarity, DAC}. SDO changes only after SCK falling edges or CS falling. SDO is zero while CS is high, and it is zero during a frame that follows no read command.
- R8: Command 10 sets a sticky power-down flag and ignores its data. While the flag is set, `dac_code_o` and all levels read zero and the active values are kept. A later valid write clears the flag.
- R9: Command 11 changes no register and no flag.
- R10: While EN is low, no register changes, and serial or LD activity during that time is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low freezes all state |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select; rising edge commits a write to the shadow copy |
| ld | input | 1 | Load strobe; rising edge copies shadow to active |
| sdo | output | 1 | Serial data out |
| dac_code_o | output | 8 | Active DAC code, zero during power-down |
| pol_swap_o | output | 1 | Active polarity-swap bit |
| level_o | output | 105 | Fifteen active 7-bit levels, level 1 in the low bits |
| power_down_o | output | 1 | Power-down flag |

## Verification
An edge on SCK, CS or LD crosses two synchronizer flops and one edge-detect flop. The register it drives therefore updates on the third clock edge after the pin changes, and the output ports follow in that same cycle. The bench holds each SCK phase for six clocks, samples SDO just before it raises SCK, and waits at least eight clocks after CS or LD rises before it compares the ports, so every check falls well after its result is due. Randomly ordered writes, loads and read-backs run against a shadow/active model kept in the bench, alongside directed short, long, reserved, power-down and frozen-enable frames.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
   typedef enum logic [1:0] {
      CMD_WRITE = 2'b00,
      CMD_READ  = 2'b01,
      CMD_PDOWN = 2'b10,
      CMD_RSVD  = 2'b11
   } cmd_e;
endpackage

// File: rtl/pcr_sync.sv
module pcr_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  st[s] <= RST_VAL;
         else if (en) begin
            if (s == 0) st[s] <= d;
            else        st[s] <= st[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/pcr_frame.sv
module pcr_frame
   import pcr_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 10,
   localparam int CNT_W  = $clog2(FRAME_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              sdi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_stb,
   output logic              pd_stb,
   output logic [ADDR_W-1:0] f_addr,
   output logic [DATA_W-1:0] f_data,
   output logic              sdo
);
   logic               sck_q, cs_q;
   logic [FRAME_W-1:0] rx_q, tx_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               rd_pend_q;
   logic [ADDR_W-1:0]  rd_addr_q;
   logic               sck_rise, sck_fall, cs_fall, cs_rise, frame_ok;
   cmd_e               cmd;

   assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
   assign sck_fall = ~sck_s & sck_q & ~cs_n_s;
   assign cs_fall  = ~cs_n_s & cs_q;
   assign cs_rise  = cs_n_s & ~cs_q;
   assign frame_ok = cs_rise && (cnt_q == CNT_W'(FRAME_W));
   assign cmd      = cmd_e'(rx_q[FRAME_W-1 -: 2]);
   assign f_addr   = rx_q[DATA_W +: ADDR_W];
   assign f_data   = rx_q[DATA_W-1:0];
   assign wr_stb   = frame_ok && (cmd == CMD_WRITE);
   assign pd_stb   = frame_ok && (cmd == CMD_PDOWN);
   assign rd_addr  = rd_addr_q;
   assign sdo      = ~cs_n_s & tx_q[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         cs_q      <= 1'b1;
         rx_q      <= '0;
         tx_q      <= '0;
         cnt_q     <= '0;
         rd_pend_q <= 1'b0;
         rd_addr_q <= '0;
      end else if (en) begin
         sck_q <= sck_s;
         cs_q  <= cs_n_s;
         if (cs_fall) begin
            cnt_q     <= '0;
            tx_q      <= rd_pend_q ? {CMD_READ, rd_addr_q, rd_data} : '0;
            rd_pend_q <= 1'b0;
         end else begin
            if (sck_rise) begin
               rx_q <= {rx_q[FRAME_W-2:0], sdi_s};
               if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end
            if (sck_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            if (frame_ok && cmd == CMD_READ) begin
               rd_pend_q <= 1'b1;
               rd_addr_q <= f_addr;
            end
         end
      end
   end

   // R7: the output shift word moves only on SCK fall or frame start
   assert_sdo_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_fall && !cs_fall) |=> $stable(tx_q));
   // R10: frozen while disabled
   assert_frozen_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(rx_q) && $stable(cnt_q) && $stable(rd_pend_q)));
endmodule

// File: rtl/pcr_regs.sv
module pcr_regs #(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 10,
   parameter int LEVEL_W = 7,
   parameter int DAC_W   = 8,
   localparam int N_LVL  = (1 << ADDR_W) - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     ld_s,
   input  logic                     wr_stb,
   input  logic                     pd_stb,
   input  logic [ADDR_W-1:0]        f_addr,
   input  logic [DATA_W-1:0]        f_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic [DAC_W-1:0]         dac_o,
   output logic                     pol_o,
   output logic [N_LVL*LEVEL_W-1:0] level_o,
   output logic                     pd_o
);
   logic               ld_q, ld_rise, pd_q;
   logic [DAC_W-1:0]   sh_dac, act_dac;
   logic               sh_pol, act_pol;
   logic [LEVEL_W-1:0] sh_lvl [N_LVL];
   logic [LEVEL_W-1:0] act_lvl [N_LVL];

   assign ld_rise = ld_s & ~ld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_q    <= 1'b0;
         pd_q    <= 1'b0;
         sh_dac  <= '0;
         sh_pol  <= 1'b0;
         act_dac <= '0;
         act_pol <= 1'b0;
      end else if (en) begin
         ld_q <= ld_s;
         if (pd_stb)      pd_q <= 1'b1;
         else if (wr_stb) pd_q <= 1'b0;
         if (wr_stb && f_addr == '0) begin
            sh_dac <= f_data[DAC_W-1:0];
            sh_pol <= f_data[DAC_W];
         end
         if (ld_rise) begin
            act_dac <= sh_dac;
            act_pol <= sh_pol;
         end
      end
   end

   for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_lvl[k]  <= '0;
            act_lvl[k] <= '0;
         end else if (en) begin
            if (wr_stb && f_addr == ADDR_W'(k + 1)) sh_lvl[k] <= f_data[LEVEL_W-1:0];
            if (ld_rise) act_lvl[k] <= sh_lvl[k];
         end
      end
      assign level_o[k*LEVEL_W +: LEVEL_W] = pd_q ? '0 : act_lvl[k];
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0) begin
         rd_data[DAC_W-1:0] = sh_dac;
         rd_data[DAC_W]     = sh_pol;
      end else begin
         rd_data[LEVEL_W-1:0] = sh_lvl[rd_addr - 1'b1];
      end
   end

   assign dac_o = pd_q ? '0 : act_dac;
   assign pol_o = act_pol;
   assign pd_o  = pd_q;

   // R4: shadow moves only on a committed write
   assert_shadow_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(sh_dac) && $stable(sh_pol) && $stable(sh_lvl[0])));
   // R5: active copy moves only on a load edge
   assert_active_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_rise |=> ($stable(act_dac) && $stable(act_pol) && $stable(act_lvl[N_LVL-1])));
   // R8: power-down command sets the flag, a write clears it
   assert_pd_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pd_stb) |=> pd_q);
   assert_pd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr_stb) |=> !pd_q);
   // R10: nothing changes while disabled
   assert_frozen_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(pd_q) && $stable(sh_dac) && $stable(act_dac)));
endmodule

// File: rtl/pam_cfg_spi_regs.sv
module pam_cfg_spi_regs #(
   parameter int FRAME_W     = 16,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 10,
   parameter int LEVEL_W     = 7,
   parameter int DAC_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int N_LVL      = (1 << ADDR_W) - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     sck,
   input  logic                     sdi,
   input  logic                     cs_n,
   input  logic                     ld,
   output logic                     sdo,
   output logic [DAC_W-1:0]         dac_code_o,
   output logic                     pol_swap_o,
   output logic [N_LVL*LEVEL_W-1:0] level_o,
   output logic                     power_down_o
);
   if (FRAME_W != 2 + ADDR_W + DATA_W) begin : g_bad_frame
      $error("frame width must equal command + address + data widths");
   end
   if (DAC_W + 1 > DATA_W || LEVEL_W > DATA_W) begin : g_bad_data
      $error("data field too narrow for DAC code plus polarity or for a level");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("at least one synchronizer stage is required");
   end

   logic [3:0]        pins_s;
   logic              wr_stb, pd_stb;
   logic [ADDR_W-1:0] f_addr, rd_addr;
   logic [DATA_W-1:0] f_data, rd_data;

   pcr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_n), .en(en),
      .d({ld, cs_n, sck, sdi}), .q(pins_s)
   );

   pcr_frame #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(en),
      .sck_s(pins_s[1]), .cs_n_s(pins_s[2]), .sdi_s(pins_s[0]),
      .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_stb(wr_stb), .pd_stb(pd_stb), .f_addr(f_addr), .f_data(f_data),
      .sdo(sdo)
   );

   pcr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .DAC_W(DAC_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .en(en), .ld_s(pins_s[3]),
      .wr_stb(wr_stb), .pd_stb(pd_stb), .f_addr(f_addr), .f_data(f_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .dac_o(dac_code_o), .pol_o(pol_swap_o), .level_o(level_o), .pd_o(power_down_o)
   );

   // R9/R6: strobes are exclusive, at most one commit action per cycle
   assert_one_action_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_stb, pd_stb}));
endmodule

// File: tb/pam_cfg_spi_regs_tb_top.sv
module pam_cfg_spi_regs_tb_top;
   localparam int NL = 15;
   localparam int LW = 7;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
   logic sck = 1'b0, sdi = 1'b0, cs_n = 1'b1, ld = 1'b0;
   logic sdo, pol_swap_o, power_down_o;
   logic [7:0] dac_code_o;
   logic [NL*LW-1:0] level_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // model state
   logic [7:0] m_sh_dac, m_act_dac;
   logic       m_sh_pol, m_act_pol, m_pd;
   logic [6:0] m_sh_lvl [1:15];
   logic [6:0] m_act_lvl [1:15];

   always #10 clk = ~clk;

   pam_cfg_spi_regs dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .sck(sck), .sdi(sdi), .cs_n(cs_n), .ld(ld),
      .sdo(sdo), .dac_code_o(dac_code_o), .pol_swap_o(pol_swap_o),
      .level_o(level_o), .power_down_o(power_down_o)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NL*LW-1:0] exp_levels();
      logic [NL*LW-1:0] v = '0;
      for (int k = 1; k <= NL; k++) v[k*LW-1 -: LW] = m_pd ? 7'd0 : m_act_lvl[k];
      return v;
   endfunction

   function automatic logic [15:0] exp_read(input logic [3:0] a);
      logic [9:0] d = '0;
      if (a == 0) d = {1'b0, m_sh_pol, m_sh_dac};
      else        d = {3'b0, m_sh_lvl[a]};
      return {2'b01, a, d};
   endfunction

   task automatic chk_outputs(input string req);
      chk({req, " dac"},   dac_code_o,   m_pd ? 8'd0 : m_act_dac);
      chk({req, " pol"},   pol_swap_o,   m_act_pol);
      chk({req, " level"}, level_o,      exp_levels());
      chk({req, " pd"},    power_down_o, m_pd);
   endtask

   // shift nbits of word, MSB first; captures SDO before each SCK rise
   task automatic xfer(input logic [31:0] word, input int nbits, output logic [31:0] got);
      got = '0;
      cs_n = 1'b0;
      wait_clk(6);
      for (int i = nbits - 1; i >= 0; i--) begin
         sdi = word[i];
         wait_clk(6);
         got = {got[30:0], sdo};
         sck = 1'b1;
         wait_clk(6);
         sck = 1'b0;
         wait_clk(6);
      end
      cs_n = 1'b1;
      wait_clk(8);
   endtask

   task automatic frame(input logic [1:0] c, input logic [3:0] a, input logic [9:0] d);
      logic [31:0] g;
      xfer({16'h0, c, a, d}, 16, g);
      if (en && c == 2'b00) begin
         m_pd = 1'b0;
         if (a == 0) begin m_sh_dac = d[7:0]; m_sh_pol = d[8]; end
         else m_sh_lvl[a] = d[6:0];
      end
      if (en && c == 2'b10) m_pd = 1'b1;
   endtask

   task automatic pulse_ld();
      ld = 1'b1;
      wait_clk(8);
      if (en) begin
         m_act_dac = m_sh_dac; m_act_pol = m_sh_pol;
         for (int k = 1; k <= NL; k++) m_act_lvl[k] = m_sh_lvl[k];
      end
      ld = 1'b0;
      wait_clk(8);
   endtask

   task automatic read_chk(input string req, input logic [3:0] a);
      logic [31:0] g;
      frame(2'b01, a, 10'h000);
      xfer({16'h0, 2'b11, 4'h0, 10'h000}, 16, g);
      chk(req, g[15:0], exp_read(a));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] g;
      int seed = 32'h5A17;
      void'($urandom(seed));
      m_sh_dac = 0; m_act_dac = 0; m_sh_pol = 0; m_act_pol = 0; m_pd = 0;
      for (int k = 1; k <= NL; k++) begin m_sh_lvl[k] = 0; m_act_lvl[k] = 0; end

      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // R1 reset state
      chk_outputs("R1 reset");
      chk("R1 sdo idle", sdo, 1'b0);

      // R2/R4: address 0 write, D9 ignored, no output change before load
      frame(2'b00, 4'd0, 10'h3A5);
      chk_outputs("R4 before load");
      pulse_ld();
      chk("R2 dac", dac_code_o, 8'hA5);
      chk("R2 pol", pol_swap_o, 1'b1);
      chk_outputs("R5 after load");

      // R3: levels, upper bits ignored, field position
      frame(2'b00, 4'd5, 10'h3FF);
      frame(2'b00, 4'd15, 10'h2AA);
      frame(2'b00, 4'd1, 10'h055);
      pulse_ld();
      chk("R3 level5", level_o[34:28], 7'h7F);
      chk("R3 level15", level_o[104:98], 7'h2A);
      chk("R3 level1", level_o[6:0], 7'h55);
      chk_outputs("R5 levels");

      // R6: short and long frames are dropped
      xfer({17'h0, 2'b00, 4'd1, 9'h011}, 15, g);
      xfer({15'h0, 2'b00, 4'd1, 10'h011, 1'b1}, 17, g);
      pulse_ld();
      chk_outputs("R6 bad length");
      read_chk("R6 shadow unchanged", 4'd1);

      // R9: reserved command has no effect
      frame(2'b11, 4'd2, 10'h07F);
      pulse_ld();
      chk_outputs("R9 reserved");
      read_chk("R9 shadow unchanged", 4'd2);

      // R7: read-back of shadow values, including an unloaded one
      read_chk("R7 addr5", 4'd5);
      read_chk("R7 addr0", 4'd0);
      frame(2'b00, 4'd3, 10'h133);
      read_chk("R7 unloaded shadow", 4'd3);
      xfer({16'h0, 2'b11, 4'd0, 10'h0}, 16, g);
      chk("R7 no pending read", g[15:0], 16'h0000);
      chk("R7 sdo cs high", sdo, 1'b0);
      pulse_ld();

      // R8: power-down forces outputs off, keeps active, write clears it
      frame(2'b10, 4'd7, 10'h3FF);
      chk_outputs("R8 pd set");
      chk("R8 dac zero", dac_code_o, 8'h00);
      frame(2'b00, 4'd9, 10'h011);
      chk_outputs("R8 pd cleared");
      chk("R8 active kept", dac_code_o, 8'hA5);
      pulse_ld();

      // R10: enable low freezes, activity lost
      en = 1'b0;
      wait_clk(2);
      frame(2'b00, 4'd0, 10'h0FF);
      frame(2'b10, 4'd0, 10'h000);
      pulse_ld();
      en = 1'b1;
      wait_clk(8);
      chk_outputs("R10 frozen");
      pulse_ld();
      chk_outputs("R10 shadow frozen");

      // random mix
      for (int it = 0; it < 60; it++) begin
         logic [3:0] a = 4'($urandom_range(0, 15));
         logic [9:0] d = 10'($urandom);
         int r = $urandom_range(0, 9);
         if (r < 6) frame(2'b00, a, d);
         else if (r == 6) frame(2'b10, a, d);
         else if (r == 7) frame(2'b11, a, d);
         else read_chk("R7 random read", a);
         if ($urandom_range(0, 1) == 1) pulse_ld();
         chk_outputs("R5 random");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule